// File: doc/BRIEF.md
# Configuration Bitstream Loader DMA

This block copies a partial configuration image from external memory into a 32-bit configuration sink with no processor involved. A single command starts a load. The command carries a word start address, a length in words and the index of the reconfigurable area that receives the image. The engine splits the load into burst read requests on a simple memory read interface. It parks the returned words in an internal FIFO and hands them to the configuration sink, one word per cycle, whenever the sink is ready.

Memory reads and sink writes are decoupled by the FIFO. As long as the memory keeps the FIFO supplied, the rate is therefore set by the sink alone. A new burst is requested only when the FIFO has room for the whole burst plus every word still in flight. When the last word has been taken, the engine pulses a completion flag and, in the same cycle, presents a location record. The record names the target area and the image start address, so a local endpoint table can be updated. All areas are the same size, so any area index is a legal target for any image.

The controller has four states, with these transitions:
- IDLE moves to FETCH when a command is accepted.
- FETCH moves to DRAIN once the last burst request has been taken.
- DRAIN moves to FINISH on the handshake of the final word.
- FINISH returns to IDLE after one cycle.

Top module: `bitload_dma`

## Requirements
- R1: After reset, `rd_req_valid`, `cfg_valid`, `done`, `loc_valid`, `cmd_ack` and `cmd_busy` are all 0.
- R2: In IDLE, a command with `cmd_len` ≠ 0 raises `cmd_ack` in the same cycle and starts a load. A command with `cmd_len` = 0 is ignored: no ack, no busy, no request and no done.
- R3: A command presented while a load is in progress raises `cmd_busy` (and no `cmd_ack`) in that cycle. "In progress" runs from the cycle after the ack through the done cycle. Such a command leaves the running load unchanged.
- R4: Read requests cover the word addresses start … start+len−1 in increasing order. Each request asks for BURST words, except the final one, which asks for the remainder. A request and its address and length are held until `rd_req_ready`.
- R5: A burst is requested only if the FIFO has free space for it plus all outstanding words, so a returned word never meets a full FIFO.
- R6: Exactly len words reach the sink, in address order. While `cfg_ready` is low, `cfg_valid` and `cfg_data` hold.
- R7: When memory returns one word per cycle with no gaps and the sink is always ready, the sink handshakes are back to back: the first and last are len−1 cycles apart.
- R8: `done` is a one-cycle pulse in the cycle right after the last sink handshake, with the FIFO empty.
- R9: `loc_valid` pulses together with `done`, and carries the command's area index on `loc_area` and its start address on `loc_base`.
- R10: Every area index from 0 to 2^AREA_W−1 is accepted as a target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Load command present |
| cmd_addr | input | ADDR_W | Image start word address |
| cmd_len | input | LEN_W | Image length in words |
| cmd_area | input | AREA_W | Target area index |
| cmd_ack | output | 1 | Command accepted this cycle |
| cmd_busy | output | 1 | Command rejected, load in progress |
| rd_req_valid | output | 1 | Burst read request |
| rd_req_addr | output | ADDR_W | Burst start word address |
| rd_req_len | output | BLEN_W | Burst length in words |
| rd_req_ready | input | 1 | Memory takes the request |
| rd_data_valid | input | 1 | Returned word valid |
| rd_data | input | DATA_W | Returned word |
| cfg_valid | output | 1 | Word offered to the sink |
| cfg_data | output | DATA_W | Word to the sink |
| cfg_ready | input | 1 | Sink takes the word |
| done | output | 1 | Load finished pulse |
| loc_valid | output | 1 | Location record valid |
| loc_area | output | AREA_W | Area of the finished load |
| loc_base | output | ADDR_W | Start address of the finished load |

## Verification
`cmd_ack` and `cmd_busy` are combinational and are due in the same cycle as the command. The first read request can appear in the cycle after the ack. A word returned at one clock edge is offered to the sink from the next cycle. `done` and the location record are due in the cycle that follows the final sink handshake. The bench drives inputs on the falling edge and samples 1 ns later, so each handshake it records is the one the rising edge will commit. It expects `done` in exactly the sampling window after the one holding the last handshake.

// File: rtl/bitload_pkg.sv
package bitload_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FETCH,
        ST_DRAIN,
        ST_FINISH
    } load_state_e;
endpackage

// File: rtl/bitload_fifo.sv
module bitload_fifo #(
    parameter int WIDTH = 32,
    parameter int DEPTH = 16,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = PTR_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             pop,
    output logic [WIDTH-1:0] head,
    output logic             empty,
    output logic [CNT_W-1:0] count
);
    logic [WIDTH-1:0] store [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (push) store[wr_ptr] <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= bump(wr_ptr);
            if (pop)  rd_ptr <= bump(rd_ptr);
            unique case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    assign head  = store[rd_ptr];
    assign empty = (count == '0);
endmodule

// File: rtl/bitload_burst.sv
module bitload_burst #(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 16,
    parameter int BURST  = 8,
    parameter int DEPTH  = 16,
    localparam int BLEN_W = $clog2(BURST) + 1,
    localparam int CNT_W  = $clog2(DEPTH) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [LEN_W-1:0]  start_len,
    input  logic              active,
    input  logic [CNT_W-1:0]  fifo_count,
    input  logic              word_in,
    input  logic              req_ready,
    output logic              req_valid,
    output logic [ADDR_W-1:0] req_addr,
    output logic [BLEN_W-1:0] req_len,
    output logic              all_issued
);
    logic [LEN_W-1:0]  left;
    logic [ADDR_W-1:0] next_addr;
    logic [CNT_W-1:0]  pending;
    logic [CNT_W-1:0]  room;
    logic [LEN_W-1:0]  chunk;
    logic              fire;

    always_comb begin
        chunk     = (left < LEN_W'(BURST)) ? left : LEN_W'(BURST);
        room      = CNT_W'(DEPTH) - fifo_count - pending;
        req_valid = active && (left != '0) && (LEN_W'(room) >= chunk);
        fire      = req_valid && req_ready;
        req_addr  = next_addr;
        req_len   = BLEN_W'(chunk);
    end

    assign all_issued = (left == '0);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            left      <= '0;
            next_addr <= '0;
            pending   <= '0;
        end else begin
            if (start) begin
                left      <= start_len;
                next_addr <= start_addr;
            end else if (fire) begin
                left      <= left - chunk;
                next_addr <= next_addr + ADDR_W'(chunk);
            end
            pending <= pending + (fire ? CNT_W'(chunk) : '0) - (word_in ? CNT_W'(1) : '0);
        end
    end
endmodule

// File: rtl/bitload_dma.sv
module bitload_dma
    import bitload_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 16,
    parameter int AREA_W = 3,
    parameter int DATA_W = 32,
    parameter int BURST  = 8,
    parameter int DEPTH  = 16,
    localparam int BLEN_W = $clog2(BURST) + 1,
    localparam int CNT_W  = $clog2(DEPTH) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [LEN_W-1:0]  cmd_len,
    input  logic [AREA_W-1:0] cmd_area,
    output logic              cmd_ack,
    output logic              cmd_busy,
    output logic              rd_req_valid,
    output logic [ADDR_W-1:0] rd_req_addr,
    output logic [BLEN_W-1:0] rd_req_len,
    input  logic              rd_req_ready,
    input  logic              rd_data_valid,
    input  logic [DATA_W-1:0] rd_data,
    output logic              cfg_valid,
    output logic [DATA_W-1:0] cfg_data,
    input  logic              cfg_ready,
    output logic              done,
    output logic              loc_valid,
    output logic [AREA_W-1:0] loc_area,
    output logic [ADDR_W-1:0] loc_base
);
    load_state_e       state, state_nx;
    logic [LEN_W-1:0]  send_left;
    logic [AREA_W-1:0] area_q;
    logic [ADDR_W-1:0] base_q;
    logic              fifo_empty;
    logic [CNT_W-1:0]  fifo_count;
    logic              cfg_fire;
    logic              fetch_on;
    logic              all_issued;

    bitload_fifo #(.WIDTH(DATA_W), .DEPTH(DEPTH)) fifo_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .push    (rd_data_valid),
        .wr_data (rd_data),
        .pop     (cfg_fire),
        .head    (cfg_data),
        .empty   (fifo_empty),
        .count   (fifo_count)
    );

    bitload_burst #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .BURST(BURST), .DEPTH(DEPTH)) burst_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (cmd_ack),
        .start_addr (cmd_addr),
        .start_len  (cmd_len),
        .active     (fetch_on),
        .fifo_count (fifo_count),
        .word_in    (rd_data_valid),
        .req_ready  (rd_req_ready),
        .req_valid  (rd_req_valid),
        .req_addr   (rd_req_addr),
        .req_len    (rd_req_len),
        .all_issued (all_issued)
    );

    assign cfg_valid = !fifo_empty;
    assign cfg_fire  = cfg_valid && cfg_ready;
    assign loc_area  = area_q;
    assign loc_base  = base_q;

    // state register and per-load context
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            send_left <= '0;
            area_q    <= '0;
            base_q    <= '0;
        end else begin
            state <= state_nx;
            if (cmd_ack) begin
                send_left <= cmd_len;
                area_q    <= cmd_area;
                base_q    <= cmd_addr;
            end else if (cfg_fire) begin
                send_left <= send_left - 1'b1;
            end
        end
    end

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (cmd_valid && cmd_len != '0) state_nx = ST_FETCH;
            ST_FETCH:  if (all_issued) state_nx = ST_DRAIN;
            ST_DRAIN:  if (cfg_fire && send_left == LEN_W'(1)) state_nx = ST_FINISH;
            ST_FINISH: state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        cmd_ack   = (state == ST_IDLE) && cmd_valid && (cmd_len != '0);
        cmd_busy  = (state != ST_IDLE) && cmd_valid;
        fetch_on  = (state == ST_FETCH);
        done      = (state == ST_FINISH);
        loc_valid = (state == ST_FINISH);
    end
endmodule

// File: rtl/bitload_dma_chk.sv
module bitload_dma_chk #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int BURST  = 8,
    parameter int DEPTH  = 16,
    localparam int BLEN_W = $clog2(BURST) + 1,
    localparam int CNT_W  = $clog2(DEPTH) + 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_ack,
    input logic              cmd_busy,
    input logic              rd_req_valid,
    input logic              rd_req_ready,
    input logic [ADDR_W-1:0] rd_req_addr,
    input logic [BLEN_W-1:0] rd_req_len,
    input logic              rd_data_valid,
    input logic [CNT_W-1:0]  fifo_count,
    input logic              cfg_valid,
    input logic              cfg_ready,
    input logic [DATA_W-1:0] cfg_data,
    input logic              done
);
    assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data_valid |-> (fifo_count < CNT_W'(DEPTH)));

    assert_req_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req_valid && !rd_req_ready) |=> (rd_req_valid && $stable(rd_req_addr) && $stable(rd_req_len)));

    assert_req_size_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_valid |-> (rd_req_len != '0 && rd_req_len <= BLEN_W'(BURST)));

    assert_cfg_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_valid && !cfg_ready) |=> (cfg_valid && $stable(cfg_data)));

    assert_done_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !cfg_valid);

    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_busy_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_busy |-> !cmd_ack);
endmodule

bind bitload_dma bitload_dma_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BURST(BURST), .DEPTH(DEPTH)
) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .cmd_ack       (cmd_ack),
    .cmd_busy      (cmd_busy),
    .rd_req_valid  (rd_req_valid),
    .rd_req_ready  (rd_req_ready),
    .rd_req_addr   (rd_req_addr),
    .rd_req_len    (rd_req_len),
    .rd_data_valid (rd_data_valid),
    .fifo_count    (fifo_count),
    .cfg_valid     (cfg_valid),
    .cfg_ready     (cfg_ready),
    .cfg_data      (cfg_data),
    .done          (done)
);

// File: tb/bitload_dma_tb_top.sv
`timescale 1ns/1ps
module bitload_dma_tb_top;
    localparam int ADDR_W = 32, LEN_W = 16, AREA_W = 3, DATA_W = 32, BURST = 8, DEPTH = 16;
    localparam int BLEN_W = $clog2(BURST) + 1;

    logic clk = 1'b0, rst_n = 1'b0;
    logic cmd_valid = 1'b0, cmd_ack, cmd_busy;
    logic [ADDR_W-1:0] cmd_addr = '0;
    logic [LEN_W-1:0]  cmd_len = '0;
    logic [AREA_W-1:0] cmd_area = '0;
    logic rd_req_valid, rd_req_ready = 1'b0, rd_data_valid = 1'b0;
    logic [ADDR_W-1:0] rd_req_addr;
    logic [BLEN_W-1:0] rd_req_len;
    logic [DATA_W-1:0] rd_data = '0;
    logic cfg_valid, cfg_ready = 1'b0, done, loc_valid;
    logic [DATA_W-1:0] cfg_data;
    logic [AREA_W-1:0] loc_area;
    logic [ADDR_W-1:0] loc_base;

    always #4 clk = ~clk;

    bitload_dma #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .AREA_W(AREA_W), .DATA_W(DATA_W),
                  .BURST(BURST), .DEPTH(DEPTH)) dut_i (.*);

    int checks = 0, errors = 0, cyc = 0;
    bit finished = 0;
    int p_req = 100, p_cfg = 100, p_mem = 100;
    bit cmd_go = 0;
    logic [ADDR_W-1:0] go_addr;
    int go_len;
    int go_area;
    bit active = 0, done_due = 0;
    logic [ADDR_W-1:0] x_base;
    int x_len, x_area, x_req, x_idx, first_hs, last_hs;
    logic [ADDR_W-1:0] mq[$];

    function automatic logic [DATA_W-1:0] mem_word(input logic [ADDR_W-1:0] a);
        return (a * 32'h9E3779B1) ^ 32'h5A5A0F0F;
    endfunction

    function automatic bit chance(input int pct);
        return ($urandom_range(99) < pct);
    endfunction

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    task automatic tick();
        @(negedge clk);
        cyc++;
        rd_req_ready = chance(p_req);
        cfg_ready    = chance(p_cfg);
        if (mq.size() > 0 && chance(p_mem)) begin
            rd_data_valid = 1'b1;
            rd_data       = mem_word(mq.pop_front());
        end else begin
            rd_data_valid = 1'b0;
        end
        cmd_valid = cmd_go;
        cmd_addr  = go_addr;
        cmd_len   = LEN_W'(go_len);
        cmd_area  = AREA_W'(go_area);
        #1;
        // command response (same cycle)
        if (cmd_valid) begin
            if (active) begin
                chk(cmd_busy && !cmd_ack, "R3", "busy on command during load", {cmd_busy, cmd_ack}, 2'b10);
            end else if (go_len == 0) begin
                chk(!cmd_busy && !cmd_ack, "R2", "zero length ignored", {cmd_busy, cmd_ack}, 2'b00);
            end else begin
                chk(cmd_ack && !cmd_busy, "R2", "command accepted", {cmd_busy, cmd_ack}, 2'b01);
            end
        end
        // completion due in the window after the last sink handshake
        if (done || done_due) begin
            chk(done == done_due, "R8", "done timing", done, done_due);
            chk(loc_valid == done_due, "R9", "loc_valid with done", loc_valid, done_due);
            if (done_due) begin
                chk(loc_area == AREA_W'(x_area), "R10", "location area", loc_area, x_area);
                chk(loc_base == x_base, "R9", "location base", loc_base, x_base);
                active   = 0;
                done_due = 0;
            end
        end
        // read request
        if (rd_req_valid && rd_req_ready) begin
            int exp_l;
            exp_l = (x_len - x_req < BURST) ? (x_len - x_req) : BURST;
            if (!active || exp_l <= 0) begin
                errors++;
                $display("FAIL R2 unexpected read request actual=%0h expected=none", rd_req_addr);
            end else begin
                chk(rd_req_addr == x_base + ADDR_W'(x_req), "R4", "burst address", rd_req_addr, x_base + ADDR_W'(x_req));
                chk(int'(rd_req_len) == exp_l, "R4", "burst length", rd_req_len, exp_l);
                for (int k = 0; k < int'(rd_req_len); k++) mq.push_back(rd_req_addr + ADDR_W'(k));
                x_req += int'(rd_req_len);
            end
        end
        // sink handshake
        if (cfg_valid && cfg_ready) begin
            if (!active || x_idx >= x_len) begin
                errors++;
                $display("FAIL R6 extra word actual=%0h expected=none", cfg_data);
            end else begin
                if (cfg_data != mem_word(x_base + ADDR_W'(x_idx))) begin
                    errors++;
                    $display("FAIL R6 word %0d actual=%0h expected=%0h", x_idx, cfg_data, mem_word(x_base + ADDR_W'(x_idx)));
                end
                if (x_idx == 0) first_hs = cyc;
                last_hs = cyc;
                x_idx++;
                if (x_idx == x_len) done_due = 1;
            end
        end
        if (cmd_valid && cmd_ack && !active) begin
            active = 1; x_base = cmd_addr; x_len = go_len; x_area = go_area;
            x_req = 0; x_idx = 0;
        end
        cmd_go = 0;
    endtask

    task automatic run_xfer(input logic [ADDR_W-1:0] a, input int len, input int area, input bit inject);
        int t;
        cmd_go = 1; go_addr = a; go_len = len; go_area = area;
        tick();
        chk(active, "R2", "load started", active, 1);
        t = 0;
        while (active && t < 6000) begin
            if (inject && (t == 5 || t == 17)) begin
                cmd_go = 1; go_addr = ~a; go_len = 3; go_area = area ^ 1;
            end
            tick();
            t++;
        end
        if (active) begin
            errors++;
            $display("FAIL R8 load timeout actual=%0d expected=%0d words", x_idx, len);
            active = 0;
        end
        chk(x_idx == len, "R6", "word count", x_idx, len);
        chk(x_req == len, "R4", "requested words", x_req, len);
        go_len = 0;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=hung expected=finished");
        report();
    end

    initial begin
        void'($urandom(32'd7741));
        go_addr = '0; go_len = 0; go_area = 0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        tick();
        chk(!rd_req_valid && !cfg_valid && !done && !loc_valid && !cmd_ack && !cmd_busy,
            "R1", "outputs after reset", {rd_req_valid, cfg_valid, done, loc_valid, cmd_ack, cmd_busy}, 0);

        // R2: zero length has no effect
        cmd_go = 1; go_addr = 32'h40; go_len = 0; go_area = 2;
        tick();
        repeat (12) tick();
        chk(!done && !rd_req_valid, "R2", "idle after zero length", {done, rd_req_valid}, 0);

        // R7: gapless stream
        p_req = 100; p_cfg = 100; p_mem = 100;
        run_xfer(32'h1000, 40, 0, 0);
        chk(last_hs - first_hs == 39, "R7", "back-to-back words", last_hs - first_hs, 39);

        // directed lengths around the burst size, top area index (R10)
        p_req = 70; p_cfg = 60; p_mem = 70;
        run_xfer(32'h2000, 1, 7, 0);
        run_xfer(32'h2100, 8, 7, 0);
        run_xfer(32'h2200, 9, 0, 0);
        run_xfer(32'h2300, 17, 4, 0);

        // R3: commands during a slow load
        p_cfg = 25;
        run_xfer(32'h3000, 30, 5, 1);

        // R5: fast memory, slow sink stresses the FIFO
        p_req = 100; p_mem = 100; p_cfg = 15;
        run_xfer(32'h3800, 45, 1, 0);

        for (int n = 0; n < 40; n++) begin
            p_req = 20 + $urandom_range(80);
            p_cfg = 20 + $urandom_range(80);
            p_mem = 20 + $urandom_range(80);
            run_xfer($urandom, 1 + $urandom_range(49), $urandom_range(7), chance(30));
            repeat ($urandom_range(3)) tick();
        end
        report();
    end
endmodule